// File: doc/BRIEF.md
# Receive Statistics Counter Bank with Threshold Status

This block keeps a bank of event counters, one per receive statistic, each advanced by a single-cycle strobe. All counters share one width, 16 or 32 bits, picked by a parameter. A three-bit control register sets how the bank behaves. One bit zeroes every counter for a single cycle and then clears itself. A second bit makes a counter hold at all-ones instead of wrapping. A third bit zeroes a counter when software reads its lowest byte.

Each counter has two sticky status bits. One sets when the counter climbs to half of its range and the other when it steps past all-ones. Both clear only when software reads that counter's lowest byte lane. A byte-wide read port returns one lane of one counter a cycle after the request and flags reads of the low lane. The interrupt output is the OR of all status bits; any masking is done outside the block.

Top module: `rx_stat_bank`

## Requirements
- R1: After synchronous reset every counter, control bit, status bit, `irq`, `rd_valid` and `rd_lo_done` is 0.
- R2: Writing control bit 0 as 1 makes `ctl_q[0]` read 1 for exactly one cycle, unless it is written again. At the end of that cycle every counter becomes 0, and strobes in that cycle are dropped. Status bits are not changed.
- R3: Each strobe on `ev_stb[i]` adds one to counter i only, in the cycle after the strobe. Several counters may count in the same cycle.
- R4: When counter i steps from 2^(W-1)-1 to 2^(W-1) (0x8000 for W=16, 0x8000_0000 for W=32), `sts_half[i]` is 1 from the next cycle.
- R5: With control bit 1 at 0, a strobe on a counter at all-ones makes it 0 and sets `sts_max[i]`.
- R6: With control bit 1 at 1, a strobe on a counter at all-ones leaves it at all-ones and still sets `sts_max[i]`.
- R7: A read with `rd_en` returns byte lane k of counter `rd_sel` (bits 8k+7..8k) on `rd_data` one cycle later, with `rd_valid` 1. A select beyond the last counter returns 0x00. `rd_lo_done` is 1 in that cycle only for a lane-0 read of an existing counter.
- R8: A lane-0 read of counter i clears both of its status bits. Reads of other lanes, or of other counters, leave them set.
- R9: With control bit 2 at 1, a lane-0 read zeroes that counter. Reads of other lanes do not change it.
- R10: A strobe and a zeroing lane-0 read of the same counter in one cycle return the old value, and the counter becomes 1. Without zeroing, the counter becomes the old value plus 1.
- R11: If a threshold crossing and a lane-0 read of the same counter fall in one cycle, the status bit ends up set.
- R12: `irq` is 1 exactly when any status bit is 1, updating in the same cycle as the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_stb | input | NUM_CNT | One-cycle count strobe per counter |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 3 | Control value: bit 0 clear all, bit 1 hold at maximum, bit 2 zero on low-lane read |
| ctl_q | output | 3 | Current control register |
| rd_en | input | 1 | Read request |
| rd_sel | input | SEL_W | Counter index to read |
| rd_lane | input | LANE_W | Byte lane to read, 0 is bits 7..0 |
| rd_data | output | 8 | Read byte, valid one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_lo_done | output | 1 | Result is from a low-lane read of an existing counter |
| sts_half | output | NUM_CNT | Half-range status per counter |
| sts_max | output | NUM_CNT | Past-maximum status per counter |
| irq | output | 1 | OR of all status bits |

## Verification
Two pairs of functions can fall in the same cycle. A counter's strobe can meet a lane-0 read of that counter, and a threshold crossing can meet a status-clearing read. The bench sets up both pairs on purpose. It strobes a counter one step below half range while reading its low lane, and it strobes a counter while reading it with zero-on-read both on and off. An arithmetic model in the bench gives the expected returned byte, the following counter value and the status bits. Every output is then compared with that model on every cycle.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int CTL_W    = 3;
  localparam int CTL_CLR  = 0;
  localparam int CTL_HOLD = 1;
  localparam int CTL_ZRD  = 2;

  typedef struct packed {
    logic zero_on_rd;
    logic hold_max;
    logic clr_all;
  } ctl_t;
endpackage

// File: rtl/rsb_ctl_reg.sv
module rsb_ctl_reg
  import rsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  ctl_t ctl_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
    end else if (we) begin
      ctl_r <= ctl_t'(wdata);
    end else begin
      // clear-all pulse lasts one cycle
      ctl_r.clr_all <= 1'b0;
    end
  end

  assign ctl = ctl_r;
endmodule

// File: rtl/rsb_counter.sv
module rsb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr_all,
  input  logic             hold_max,
  input  logic             zero_on_rd,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] cnt,
  output logic             half_q,
  output logic             max_q,
  output logic             half_d,
  output logic             max_d
);
  localparam logic [CNT_W-1:0] ALL1    = '1;
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_zero, live_inc, half_hit, max_hit;

  always_comb begin
    rd_zero  = rd_lo & zero_on_rd;
    live_inc = inc & ~clr_all & ~rd_zero;
    half_hit = live_inc & (cnt_q == HALF_M1);
    max_hit  = live_inc & (cnt_q == ALL1);

    if (clr_all) begin
      cnt_d = '0;
    end else if (rd_zero) begin
      cnt_d = {{(CNT_W-1){1'b0}}, inc};
    end else if (inc) begin
      if (cnt_q == ALL1) cnt_d = hold_max ? ALL1 : '0;
      else               cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end

    // set has priority over the read clear
    half_d = (half_q & ~rd_lo) | half_hit;
    max_d  = (max_q  & ~rd_lo) | max_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      max_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      max_q  <= max_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rsb_rd_mux.sv
module rsb_rd_mux #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 3,
  parameter int LANE_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  logic [SEL_W-1:0]                rd_sel,
  input  logic [LANE_W-1:0]               rd_lane,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
  output logic [7:0]                      rd_data,
  output logic                            rd_valid,
  output logic                            rd_lo
);
  localparam int LANES = CNT_W / 8;

  logic [CNT_W-1:0] word, shifted;
  logic [7:0]       byte_d;
  logic             sel_ok, lane_ok;

  always_comb begin
    sel_ok  = (32'(rd_sel) < NUM_CNT);
    lane_ok = (32'(rd_lane) < LANES);
    word    = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (32'(rd_sel) == k) word = cnt_all[k];
    end
    shifted = word >> (32'(rd_lane) * 8);
    byte_d  = (sel_ok && lane_ok) ? shifted[7:0] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_lo    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_lo    <= rd_en && sel_ok && (rd_lane == '0);
      if (rd_en) rd_data <= byte_d;
    end
  end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
  import rsb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  localparam int LANES  = CNT_W / 8,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] ev_stb,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_q,
  input  logic               rd_en,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [LANE_W-1:0]  rd_lane,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  output logic               rd_lo_done,
  output logic [NUM_CNT-1:0] sts_half,
  output logic [NUM_CNT-1:0] sts_max,
  output logic               irq
);
  ctl_t                          ctl;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            half_d, max_d;
  logic                          irq_q;

  rsb_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic lo_hit;
    assign lo_hit = rd_en && (rd_lane == '0) && (rd_sel == SEL_W'(i));

    rsb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc        (ev_stb[i]),
      .clr_all    (ctl.clr_all),
      .hold_max   (ctl.hold_max),
      .zero_on_rd (ctl.zero_on_rd),
      .rd_lo      (lo_hit),
      .cnt        (cnt_all[i]),
      .half_q     (sts_half[i]),
      .max_q      (sts_max[i]),
      .half_d     (half_d[i]),
      .max_d      (max_d[i])
    );
  end

  rsb_rd_mux #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W),
    .LANE_W  (LANE_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_lane  (rd_lane),
    .cnt_all  (cnt_all),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_lo    (rd_lo_done)
  );

  // registered from next-state so it lines up with the status flops
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |{half_d, max_d};
  end

  assign irq   = irq_q;
  assign ctl_q = ctl;
endmodule

// File: rtl/rsb_chk.sv
module rsb_chk #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 3,
  parameter int LANE_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CNT-1:0] ev_stb,
  input logic               ctl_we,
  input logic [2:0]         ctl_q,
  input logic               rd_en,
  input logic [SEL_W-1:0]   rd_sel,
  input logic [LANE_W-1:0]  rd_lane,
  input logic [7:0]         rd_data,
  input logic               rd_valid,
  input logic               rd_lo_done,
  input logic [NUM_CNT-1:0] sts_half,
  input logic [NUM_CNT-1:0] sts_max,
  input logic               irq
);
  p_clr_self_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && !ctl_we) |=> !ctl_q[0]);

  p_clr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(ctl_q[0])) |=> (rd_data == 8'h00));

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_lo_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_lo_done |-> rd_valid);

  p_irq_or_r12: assert property (@(posedge clk) disable iff (rst)
    irq == ((|sts_half) || (|sts_max)));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_st
    p_half_rise_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_half[i]) |-> $past(ev_stb[i]));

    p_max_rise_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_max[i]) |-> $past(ev_stb[i]));

    p_half_fall_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(sts_half[i]) |-> $past(rd_en && (rd_lane == '0) && (rd_sel == SEL_W'(i))));

    p_max_fall_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(sts_max[i]) |-> $past(rd_en && (rd_lane == '0) && (rd_sel == SEL_W'(i))));
  end
endmodule

bind rx_stat_bank rsb_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .SEL_W   (SEL_W),
  .LANE_W  (LANE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_stb     (ev_stb),
  .ctl_we     (ctl_we),
  .ctl_q      (ctl_q),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_lane    (rd_lane),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .rd_lo_done (rd_lo_done),
  .sts_half   (sts_half),
  .sts_max    (sts_max),
  .irq        (irq)
);

// File: tb/sim_rx_stat_bank.sv
`timescale 1ns/1ps
module sim_rx_stat_bank;
  localparam int N     = 3;
  localparam int W     = 16;
  localparam int MAXV  = (1 << W) - 1;
  localparam int HALFV = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ev_stb = '0;
  logic         ctl_we = 1'b0;
  logic [2:0]   ctl_wdata = '0;
  logic [2:0]   ctl_q;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = '0;
  logic [0:0]   rd_lane = '0;
  logic [7:0]   rd_data;
  logic         rd_valid, rd_lo_done, irq;
  logic [N-1:0] sts_half, sts_max;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  int         m_cnt [N];
  logic [N-1:0] m_half = '0, m_max = '0;
  logic [2:0] m_ctl = '0;

  always #2 clk = ~clk;

  rx_stat_bank #(.NUM_CNT(N), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .ev_stb(ev_stb), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .rd_en(rd_en), .rd_sel(rd_sel), .rd_lane(rd_lane),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_lo_done(rd_lo_done),
    .sts_half(sts_half), .sts_max(sts_max), .irq(irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] ev, input logic re, input logic [1:0] sel,
                     input logic ln, input logic cw, input logic [2:0] cd);
    int   e_rd;
    logic e_lo, clr, rdlo, rdz;
    @(negedge clk);
    ev_stb = ev; rd_en = re; rd_sel = sel; rd_lane = ln; ctl_we = cw; ctl_wdata = cd;
    e_rd = 0;
    if (re && sel < N) e_rd = (m_cnt[sel] >> (8 * ln)) & 255;
    e_lo = re && (ln == 0) && (sel < N);
    clr  = m_ctl[0];
    for (int i = 0; i < N; i++) begin
      logic hh, hm;
      hh = 0; hm = 0;
      rdlo = re && (ln == 0) && (sel == i);
      rdz  = rdlo && m_ctl[2];
      if (clr) m_cnt[i] = 0;
      else if (rdz) m_cnt[i] = ev[i] ? 1 : 0;
      else if (ev[i]) begin
        if (m_cnt[i] == MAXV) begin
          hm = 1; m_cnt[i] = m_ctl[1] ? MAXV : 0;
        end else begin
          if (m_cnt[i] == HALFV - 1) hh = 1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      m_half[i] = (m_half[i] & ~rdlo) | hh;
      m_max[i]  = (m_max[i] & ~rdlo) | hm;
    end
    m_ctl = cw ? cd : {m_ctl[2:1], 1'b0};
    @(posedge clk); #1;
    chk("rd_valid", int'(rd_valid), int'(re));
    if (re) begin
      chk("rd_data", int'(rd_data), e_rd);
      chk("rd_lo_done", int'(rd_lo_done), int'(e_lo));
    end
    chk("sts_half", int'(sts_half), int'(m_half));
    chk("sts_max", int'(sts_max), int'(m_max));
    chk("irq", int'(irq), int'(|{m_half, m_max}));
    chk("ctl_q", int'(ctl_q), int'(m_ctl));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc('0, 0, 0, 0, 0, 3'b000);
  endtask

  task automatic rd(input logic [1:0] sel, input logic ln);
    cyc('0, 1, sel, ln, 0, 3'b000);
  endtask

  task automatic run(input logic [N-1:0] ev, input int n);
    for (int k = 0; k < n; k++) cyc(ev, 0, 0, 0, 0, 3'b000);
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    cyc('0, 0, 0, 0, 1, v);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    tag = "R1";
    idle(1);
    for (int i = 0; i < N; i++) rd(2'(i), 0);

    // R3 / R7: random strobes and reads, out-of-range select included
    tag = "R3";
    for (int k = 0; k < 400; k++) begin
      if (k == 200) wr_ctl(3'b100);
      cyc(N'($urandom % 8), 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), 0, 3'b000);
    end
    wr_ctl(3'b000);
    tag = "R7";
    rd(2'd3, 0); rd(2'd3, 1);
    for (int i = 0; i < N; i++) begin rd(2'(i), 1); rd(2'(i), 0); end

    // R2: clear-all with strobes during the pulse, status kept
    tag = "R2";
    cyc('1, 0, 0, 0, 1, 3'b001);
    cyc('1, 0, 0, 0, 0, 3'b000);
    for (int i = 0; i < N; i++) rd(2'(i), 0);
    cyc('0, 0, 0, 0, 1, 3'b001);
    cyc('0, 0, 0, 0, 1, 3'b001);
    idle(2);
    for (int i = 0; i < N; i++) rd(2'(i), 1);

    // R4: half-range crossing
    tag = "R4";
    run(3'b111, HALFV - 2);
    run(3'b011, 1);
    run(3'b111, 1);
    rd(0, 1); rd(1, 1);
    // R11: crossing meets a low-lane read of the same counter
    tag = "R11";
    cyc(3'b100, 1, 2, 0, 0, 3'b000);
    idle(1);
    // R8: only a lane-0 read of the owning counter clears status
    tag = "R8";
    rd(0, 1); rd(2'd3, 0); rd(0, 0); rd(1, 1); rd(1, 0); rd(2, 0);

    // R6: hold at all-ones
    tag = "R6";
    run(3'b111, MAXV - 1 - HALFV);
    wr_ctl(3'b010);
    run(3'b010, 4);
    rd(1, 1); rd(1, 0);
    run(3'b010, 1);
    // R5: wrap to zero
    tag = "R5";
    wr_ctl(3'b000);
    run(3'b001, 2);
    rd(0, 1); rd(0, 0);

    // R9: zero on low-lane read
    tag = "R9";
    wr_ctl(3'b100);
    run(3'b100, 3);
    rd(2, 1); rd(2, 1); rd(2, 0); rd(2, 0); rd(2, 1);
    // R10: strobe and read together
    tag = "R10";
    run(3'b100, 5);
    cyc(3'b100, 1, 2, 0, 0, 3'b000);
    rd(2, 0); rd(2, 0);
    wr_ctl(3'b000);
    run(3'b001, 7);
    cyc(3'b001, 1, 0, 0, 0, 3'b000);
    rd(0, 0);

    // R12: irq drops once every status bit is gone
    tag = "R12";
    for (int i = 0; i < N; i++) rd(2'(i), 0);
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule